// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit carries out the data-memory instructions of a 32-bit load/store processor. Each cycle it may accept one decoded instruction: a 6-bit opcode, the base register value, a 16-bit signed displacement, the destination register index and the store data from the register file. It adds the sign-extended displacement to the base to get the effective address. It then drives a word-wide synchronous memory through registered request outputs: a word address, per-byte write enables, write data and a write flag.

Read data comes back one cycle after the memory samples the request. The unit picks the addressed byte lane, or the whole word, and applies sign or zero extension. It returns the result with a one-cycle valid strobe and the destination index. A compile-time parameter sets the byte lane numbering to big-endian or little-endian. A word access whose address is not a multiple of four sends nothing to memory. Instead it raises a one-cycle fault that carries the offending address.

Top module: `lsu_core`

## Requirements
- R1: The effective address is `issue_base` plus `issue_imm` sign-extended to 32 bits (range -32768..32767). `mem_waddr` carries effective address bits 31:2.
- R2: Opcode 35 is word load, 43 word store, 32 signed byte load, 36 unsigned byte load and 40 byte store. Any other opcode presented with `issue_valid` produces no memory request, no fault and no load result.
- R3: A word store at an aligned address makes `mem_req` and `mem_we` high for one cycle, starting on the clock edge that samples the issue. In that cycle `mem_be` = 4'b1111 and `mem_wdata` equals the store data.
- R4: A byte store drives `issue_sdata[7:0]` on all four lanes of `mem_wdata` and raises exactly one `mem_be` bit, the one for the addressed lane. The other three bytes of the memory word keep their contents.
- R5: Lane k is bits 8k+7:8k, and `mem_be[k]` enables lane k. With `BIG_ENDIAN`=1, address offset o (address bits 1:0) maps to lane 3-o, so offset 0 is bits 31:24. With `BIG_ENDIAN`=0, offset o maps to lane o.
- R6: A load makes `mem_req` high with `mem_we` low and `mem_be` = 4'b1111 for one cycle. Two clock edges after that request is driven, `ld_valid` is high for one cycle, with `ld_rt` equal to the issued `issue_rt`.
- R7: A word load returns the full 32-bit memory word.
- R8: A signed byte load returns the addressed byte in bits 7:0, with its bit 7 copied into bits 31:8.
- R9: An unsigned byte load returns the addressed byte in bits 7:0, with bits 31:8 zero.
- R10: A word load or store whose effective address has nonzero bits 1:0 issues no memory request. It raises `fault_valid` for one cycle, with `fault_addr` equal to the effective address. Byte accesses never fault.
- R11: Instructions may be issued on consecutive cycles. Their load results come back on consecutive cycles in issue order.
- R12: `rst` (synchronous, active high) clears all outputs to zero and drops every load in flight, so no `ld_valid` follows a reset.
- R13: After storing word 0x23456789 at address 0, a signed byte load from address 1 returns 0x00000045 with `BIG_ENDIAN`=1 and 0x00000067 with `BIG_ENDIAN`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_op | input | 6 | Opcode |
| issue_base | input | 32 | Base register value |
| issue_imm | input | 16 | Signed displacement |
| issue_rt | input | 5 | Destination register index |
| issue_sdata | input | 32 | Store data |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ld_valid | output | 1 | Load result strobe |
| ld_rt | output | 5 | Load destination index |
| ld_data | output | 32 | Aligned, extended load result |
| fault_valid | output | 1 | Misaligned-access fault strobe |
| fault_addr | output | 32 | Faulting effective address |

## Verification
The bench runs a big-endian and a little-endian instance side by side. Against a shadow memory it sweeps every byte offset of sixteen words with signed and unsigned byte loads. A lane map that is mirrored, or wrong only in one mode, returns the wrong byte at some offset. Bytes with bit 7 set catch missing or wrongly applied sign extension. Byte stores into pre-filled words, each followed by a word reload, expose a design that writes neighbouring bytes. Negative displacements expose a design that zero-extends the immediate, because the word address lands in the wrong place. Every misaligned word offset, all 59 unassigned opcodes, back-to-back loads and a reset in mid-flight catch a design that still sends requests, loses ordering or leaks a stale result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LB  = 6'd32;
  localparam logic [OPC_W-1:0] OPC_LW  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_LBU = 6'd36;
  localparam logic [OPC_W-1:0] OPC_SB  = 6'd40;
  localparam logic [OPC_W-1:0] OPC_SW  = 6'd43;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_LW,
    ACC_SW,
    ACC_LB,
    ACC_LBU,
    ACC_SB
  } acc_e;

  typedef struct packed {
    logic is_load;
    logic is_store;
    logic is_byte;
    logic sext;
  } acc_attr_t;

  function automatic acc_e decode_op(input logic [OPC_W-1:0] op);
    case (op)
      OPC_LW:  return ACC_LW;
      OPC_SW:  return ACC_SW;
      OPC_LB:  return ACC_LB;
      OPC_LBU: return ACC_LBU;
      OPC_SB:  return ACC_SB;
      default: return ACC_NONE;
    endcase
  endfunction

  function automatic acc_attr_t attr_of(input acc_e acc);
    acc_attr_t a;
    a.is_load  = (acc == ACC_LW) || (acc == ACC_LB) || (acc == ACC_LBU);
    a.is_store = (acc == ACC_SW) || (acc == ACC_SB);
    a.is_byte  = (acc == ACC_LB) || (acc == ACC_LBU) || (acc == ACC_SB);
    a.sext     = (acc == ACC_LB);
    return a;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int OFF_W = 2
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic             word_acc,
  output logic [XLEN-1:0]  ea,
  output logic [OFF_W-1:0] off,
  output logic             misaligned
);

  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext    = {{EXT_W{imm[IMM_W-1]}}, imm};
    ea         = base + imm_ext;
    off        = ea[OFF_W-1:0];
    misaligned = word_acc && (off != '0);
  end

endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt #(
  parameter int XLEN       = 32,
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int LANES      = XLEN / 8,
  parameter int OFF_W      = $clog2(LANES)
) (
  input  logic             is_byte,
  input  logic [OFF_W-1:0] off,
  input  logic [XLEN-1:0]  sdata,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  wdata
);

  localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

  logic [OFF_W-1:0] lane;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = TOP_LANE - off;
    end else begin : g_little
      assign lane = off;
    end
  endgenerate

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be[g]          = !is_byte || (lane == OFF_W'(g));
      assign wdata[8*g +: 8] = is_byte ? sdata[7:0] : sdata[8*g +: 8];
    end
  endgenerate

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt #(
  parameter int XLEN       = 32,
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int LANES      = XLEN / 8,
  parameter int OFF_W      = $clog2(LANES)
) (
  input  logic [XLEN-1:0]  rdata,
  input  logic [OFF_W-1:0] off,
  input  logic             is_byte,
  input  logic             sext,
  output logic [XLEN-1:0]  result
);

  localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

  logic [OFF_W-1:0] lane;
  logic [7:0]       sel;
  logic             fill;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = TOP_LANE - off;
    end else begin : g_little
      assign lane = off;
    end
  endgenerate

  always_comb begin
    sel = rdata[7:0];
    for (int k = 0; k < LANES; k++) begin
      if (lane == OFF_W'(k)) sel = rdata[8*k +: 8];
    end
    fill = sext && sel[7];
    if (is_byte) result = {{(XLEN-8){fill}}, sel};
    else         result = rdata;
  end

endmodule

// File: rtl/lsu_core.sv
module lsu_core #(
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int XLEN       = 32,
  parameter int IMM_W      = 16,
  parameter int RIDX_W     = 5,
  parameter int OPC_W      = lsu_pkg::OPC_W,
  parameter int LANES      = XLEN / 8,
  parameter int OFF_W      = $clog2(LANES),
  parameter int WADDR_W    = XLEN - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_valid,
  input  logic [OPC_W-1:0]   issue_op,
  input  logic [XLEN-1:0]    issue_base,
  input  logic [IMM_W-1:0]   issue_imm,
  input  logic [RIDX_W-1:0]  issue_rt,
  input  logic [XLEN-1:0]    issue_sdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_waddr,
  output logic [LANES-1:0]   mem_be,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               ld_valid,
  output logic [RIDX_W-1:0]  ld_rt,
  output logic [XLEN-1:0]    ld_data,
  output logic               fault_valid,
  output logic [XLEN-1:0]    fault_addr
);

  import lsu_pkg::*;

  // decode
  acc_e      acc;
  acc_attr_t attr;
  logic      word_acc;

  always_comb begin
    acc      = decode_op(issue_op);
    attr     = attr_of(acc);
    word_acc = (acc == ACC_LW) || (acc == ACC_SW);
  end

  // address
  logic [XLEN-1:0]  ea;
  logic [OFF_W-1:0] ea_off;
  logic             misaligned;

  lsu_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W)) addr_i (
    .base       (issue_base),
    .imm        (issue_imm),
    .word_acc   (word_acc),
    .ea         (ea),
    .off        (ea_off),
    .misaligned (misaligned)
  );

  // store lane steering
  logic [LANES-1:0] st_be;
  logic [XLEN-1:0]  st_wdata;

  lsu_store_fmt #(.XLEN(XLEN), .BIG_ENDIAN(BIG_ENDIAN), .LANES(LANES), .OFF_W(OFF_W)) st_i (
    .is_byte (attr.is_byte),
    .off     (ea_off),
    .sdata   (issue_sdata),
    .be      (st_be),
    .wdata   (st_wdata)
  );

  logic go_mem, go_load, go_store, go_fault;

  always_comb begin
    go_mem   = issue_valid && (attr.is_load || attr.is_store) && !misaligned;
    go_load  = go_mem && attr.is_load;
    go_store = go_mem && attr.is_store;
    go_fault = issue_valid && misaligned;
  end

  // request stage and fault
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_waddr   <= '0;
      mem_be      <= '0;
      mem_wdata   <= '0;
      fault_valid <= 1'b0;
      fault_addr  <= '0;
    end else begin
      mem_req     <= go_mem;
      mem_we      <= go_store;
      fault_valid <= go_fault;
      if (go_fault) fault_addr <= ea;
      if (go_mem) begin
        mem_waddr <= ea[XLEN-1:OFF_W];
        mem_be    <= go_store ? st_be : {LANES{1'b1}};
        mem_wdata <= go_store ? st_wdata : '0;
      end
    end
  end

  // load tag pipeline: stage 1 aligns with the request, stage 2 with read data
  logic              t1_vld, t2_vld;
  logic              t1_byte, t2_byte;
  logic              t1_sext, t2_sext;
  logic [OFF_W-1:0]  t1_off, t2_off;
  logic [RIDX_W-1:0] t1_rt, t2_rt;

  always_ff @(posedge clk) begin
    if (rst) begin
      t1_vld  <= 1'b0;
      t1_byte <= 1'b0;
      t1_sext <= 1'b0;
      t1_off  <= '0;
      t1_rt   <= '0;
      t2_vld  <= 1'b0;
      t2_byte <= 1'b0;
      t2_sext <= 1'b0;
      t2_off  <= '0;
      t2_rt   <= '0;
    end else begin
      t1_vld <= go_load;
      if (go_load) begin
        t1_byte <= attr.is_byte;
        t1_sext <= attr.sext;
        t1_off  <= ea_off;
        t1_rt   <= issue_rt;
      end
      t2_vld <= t1_vld;
      if (t1_vld) begin
        t2_byte <= t1_byte;
        t2_sext <= t1_sext;
        t2_off  <= t1_off;
        t2_rt   <= t1_rt;
      end
    end
  end

  // result alignment
  logic [XLEN-1:0] ld_fmt;

  lsu_load_fmt #(.XLEN(XLEN), .BIG_ENDIAN(BIG_ENDIAN), .LANES(LANES), .OFF_W(OFF_W)) ld_i (
    .rdata   (mem_rdata),
    .off     (t2_off),
    .is_byte (t2_byte),
    .sext    (t2_sext),
    .result  (ld_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_rt    <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= t2_vld;
      if (t2_vld) begin
        ld_rt   <= t2_rt;
        ld_data <= ld_fmt;
      end
    end
  end

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int XLEN  = 32,
  parameter int LANES = XLEN / 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic             mem_we,
  input logic [LANES-1:0] mem_be,
  input logic [XLEN-1:0]  mem_wdata,
  input logic             ld_valid,
  input logic             fault_valid,
  input logic [XLEN-1:0]  fault_addr
);

  logic repl_ok;
  always_comb begin
    repl_ok = 1'b1;
    for (int k = 1; k < LANES; k++) begin
      if (mem_wdata[8*k +: 8] != mem_wdata[7:0]) repl_ok = 1'b0;
    end
  end

  // R10
  fault_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> !mem_req);

  // R10
  fault_addr_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_addr[OFF_W-1:0] != '0));

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> ##1 ld_valid);

  // R6
  ld_source_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_req && !mem_we, 2));

  // R6
  rd_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (&mem_be));

  // R4
  wr_enable_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (($countones(mem_be) == 1) || (&mem_be)));

  // R4
  byte_repl_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && ($countones(mem_be) == 1)) |-> repl_ok);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !ld_valid && !fault_valid));

endmodule

bind lsu_core lsu_core_chk #(.XLEN(XLEN), .LANES(LANES), .OFF_W(OFF_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .mem_wdata   (mem_wdata),
  .ld_valid    (ld_valid),
  .fault_valid (fault_valid),
  .fault_addr  (fault_addr)
);

// File: tb/lsu_core_tb_top.sv
module lsu_tb_mem #(
  parameter int IDX_W = 4
) (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [29:0] waddr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] mem [2**IDX_W];
  initial begin
    for (int i = 0; i < 2**IDX_W; i++) mem[i] = 32'h0;
    rdata = 32'h0;
  end
  always @(posedge clk) begin
    if (req && we) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) mem[waddr[IDX_W-1:0]][8*k +: 8] <= wdata[8*k +: 8];
    end else if (req) begin
      rdata <= mem[waddr[IDX_W-1:0]];
    end
  end
endmodule

module lsu_core_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        iv = 1'b0;
  logic [5:0]  iop = 6'd0;
  logic [31:0] ibase = 32'h0;
  logic [15:0] iimm = 16'h0;
  logic [4:0]  irt = 5'd0;
  logic [31:0] isd = 32'h0;

  // index 0: big-endian instance, index 1: little-endian instance
  logic        req [2];
  logic        we [2];
  logic [29:0] wa [2];
  logic [3:0]  be [2];
  logic [31:0] wd [2];
  logic [31:0] rd [2];
  logic        lv [2];
  logic [4:0]  lrt [2];
  logic [31:0] ldat [2];
  logic        fv [2];
  logic [31:0] fa [2];

  lsu_core #(.BIG_ENDIAN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_op(iop), .issue_base(ibase),
    .issue_imm(iimm), .issue_rt(irt), .issue_sdata(isd),
    .mem_req(req[0]), .mem_we(we[0]), .mem_waddr(wa[0]), .mem_be(be[0]),
    .mem_wdata(wd[0]), .mem_rdata(rd[0]), .ld_valid(lv[0]), .ld_rt(lrt[0]),
    .ld_data(ldat[0]), .fault_valid(fv[0]), .fault_addr(fa[0]));

  lsu_core #(.BIG_ENDIAN(1'b0)) dut_le (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_op(iop), .issue_base(ibase),
    .issue_imm(iimm), .issue_rt(irt), .issue_sdata(isd),
    .mem_req(req[1]), .mem_we(we[1]), .mem_waddr(wa[1]), .mem_be(be[1]),
    .mem_wdata(wd[1]), .mem_rdata(rd[1]), .ld_valid(lv[1]), .ld_rt(lrt[1]),
    .ld_data(ldat[1]), .fault_valid(fv[1]), .fault_addr(fa[1]));

  lsu_tb_mem mem_be_i (.clk(clk), .req(req[0]), .we(we[0]), .waddr(wa[0]),
    .be(be[0]), .wdata(wd[0]), .rdata(rd[0]));
  lsu_tb_mem mem_le_i (.clk(clk), .req(req[1]), .we(we[1]), .waddr(wa[1]),
    .be(be[1]), .wdata(wd[1]), .rdata(rd[1]));

  int nvec = 0;
  int nfail = 0;
  logic [31:0] shadow [2][16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int shift_of(input int e, input logic [1:0] off);
    return (e == 0) ? (3 - int'(off)) * 8 : int'(off) * 8;
  endfunction

  function automatic logic [31:0] eff(input logic [31:0] b, input logic [15:0] i);
    return b + {{16{i[15]}}, i};
  endfunction

  task automatic issue(input logic [5:0] op, input logic [31:0] b, input logic [15:0] i,
                       input logic [4:0] rt, input logic [31:0] sd);
    @(negedge clk);
    iv = 1'b1; iop = op; ibase = b; iimm = i; irt = rt; isd = sd;
    @(negedge clk);
    iv = 1'b0;
  endtask

  task automatic do_store(input logic [5:0] op, input logic [31:0] b, input logic [15:0] i,
                          input logic [31:0] sd);
    logic [31:0] ea;
    ea = eff(b, i);
    issue(op, b, i, 5'd0, sd);
    for (int e = 0; e < 2; e++) begin
      int sh;
      sh = shift_of(e, ea[1:0]);
      chk("R3 store req", {30'd0, req[e], we[e]}, 32'd3);
      chk("R1 store waddr", {2'b0, wa[e]}, {2'b0, ea[31:2]});
      if (op == 6'd43) begin
        chk("R3 word store be", {28'd0, be[e]}, 32'hF);
        chk("R3 word store data", wd[e], sd);
        shadow[e][ea[5:2]] = sd;
      end else begin
        chk("R4 R5 byte store be", {28'd0, be[e]}, 32'd1 << (sh / 8));
        chk("R4 byte store data", wd[e], {4{sd[7:0]}});
        shadow[e][ea[5:2]][sh +: 8] = sd[7:0];
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_ld(input int e, input logic [5:0] op,
                                         input logic [31:0] ea);
    logic [31:0] w;
    logic [7:0]  bt;
    w  = shadow[e][ea[5:2]];
    bt = w[shift_of(e, ea[1:0]) +: 8];
    if (op == 6'd35) return w;
    if (op == 6'd32) return {{24{bt[7]}}, bt};
    return {24'h0, bt};
  endfunction

  task automatic do_load(input logic [5:0] op, input logic [31:0] b, input logic [15:0] i,
                         input logic [4:0] rt, input string tag);
    logic [31:0] ea;
    ea = eff(b, i);
    issue(op, b, i, rt, 32'hDEAD_BEEF);
    for (int e = 0; e < 2; e++) begin
      chk("R6 load req", {29'd0, req[e], we[e], &be[e]}, 32'd5);
      chk("R1 load waddr", {2'b0, wa[e]}, {2'b0, ea[31:2]});
    end
    @(negedge clk);
    for (int e = 0; e < 2; e++) chk("R6 no early valid", {31'd0, lv[e]}, 32'd0);
    @(negedge clk);
    for (int e = 0; e < 2; e++) begin
      chk("R6 valid", {31'd0, lv[e]}, 32'd1);
      chk("R6 rt", {27'd0, lrt[e]}, {27'd0, rt});
      chk(tag, ldat[e], exp_ld(e, op, ea));
    end
    @(negedge clk);
    for (int e = 0; e < 2; e++) chk("R6 one-cycle valid", {31'd0, lv[e]}, 32'd0);
  endtask

  task automatic do_fault(input logic [5:0] op, input logic [31:0] b, input logic [15:0] i);
    logic [31:0] ea;
    ea = eff(b, i);
    issue(op, b, i, 5'd7, 32'h1111_1111);
    for (int e = 0; e < 2; e++) begin
      chk("R10 fault strobe, no req", {30'd0, fv[e], req[e]}, 32'd2);
      chk("R10 fault addr", fa[e], ea);
    end
    @(negedge clk);
    for (int e = 0; e < 2; e++) chk("R10 fault one cycle", {31'd0, fv[e]}, 32'd0);
    @(negedge clk);
    for (int e = 0; e < 2; e++) chk("R10 no result", {31'd0, lv[e]}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int e = 0; e < 2; e++)
      for (int w = 0; w < 16; w++) shadow[e][w] = 32'h0;
    repeat (3) @(negedge clk);
    for (int e = 0; e < 2; e++) begin
      chk("R12 reset outputs", {29'd0, req[e], lv[e], fv[e]}, 32'd0);
      chk("R12 reset data", ldat[e] | fa[e] | wd[e], 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R13 lane-numbering example
    do_store(6'd43, 32'h0, 16'h0, 32'h2345_6789);
    issue(6'd32, 32'h0, 16'h1, 5'd9, 32'h0);
    repeat (2) @(negedge clk);
    chk("R13 big-endian byte 1", ldat[0], 32'h0000_0045);
    chk("R13 little-endian byte 1", ldat[1], 32'h0000_0067);

    // R1 R3: fill words via negative displacements
    for (int w = 0; w < 16; w++)
      do_store(6'd43, 32'h0000_0140, 16'(w * 4 - 64),
               32'h8A3C_F10E ^ (32'(w) * 32'h1357_9BDF));
    // R7 word loads
    for (int w = 0; w < 16; w++)
      do_load(6'd35, 32'h0000_0100, 16'(w * 4), 5'(w), "R7 word load");
    // R8 R9 R5 every byte offset, both extensions
    for (int a = 0; a < 64; a++) begin
      do_load(6'd32, 32'h0000_0200, 16'(a - 256), 5'(a), "R8 signed byte load");
      do_load(6'd36, 32'h0000_0100, 16'(a), 5'(31 - a % 32), "R9 unsigned byte load");
    end
    // R4 byte stores into filled words, then reload words
    for (int a = 0; a < 16; a++)
      do_store(6'd40, 32'h0000_0300, 16'(a - 512), 32'hF0F0_F000 | 32'(8'h81 + a * 9));
    for (int w = 0; w < 4; w++)
      do_load(6'd35, 32'h0000_0100, 16'(w * 4), 5'd3, "R4 neighbours unchanged");
    // R10 misaligned word accesses; byte accesses at the same offsets do not fault
    for (int o = 1; o < 4; o++) begin
      do_fault(6'd35, 32'h1000_0020, 16'(o - 8));
      do_fault(6'd43, 32'h0000_0010, 16'(o));
      do_load(6'd36, 32'h0000_0100, 16'(o), 5'd1, "R10 byte load no fault");
    end
    // R2 unassigned opcodes are ignored
    for (int op = 0; op < 64; op++) begin
      if (op != 32 && op != 35 && op != 36 && op != 40 && op != 43) begin
        issue(6'(op), 32'h0000_0100, 16'h0, 5'd2, 32'hFFFF_FFFF);
        for (int e = 0; e < 2; e++)
          chk("R2 ignored opcode", {30'd0, req[e], fv[e]}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        for (int e = 0; e < 2; e++) chk("R2 no result", {31'd0, lv[e]}, 32'd0);
      end
    end
    do_load(6'd35, 32'h0000_0100, 16'h0, 5'd4, "R2 memory untouched");

    // R11 back-to-back loads
    @(negedge clk);
    iv = 1'b1; iop = 6'd35; ibase = 32'h0000_0100; iimm = 16'd4; irt = 5'd11;
    @(negedge clk);
    iop = 6'd36; iimm = 16'd9; irt = 5'd12;
    @(negedge clk);
    iv = 1'b0;
    @(negedge clk);
    for (int e = 0; e < 2; e++) begin
      chk("R11 first result", {26'd0, lv[e], lrt[e]}, {26'd0, 1'b1, 5'd11});
      chk("R11 first data", ldat[e], exp_ld(e, 6'd35, 32'h104));
    end
    @(negedge clk);
    for (int e = 0; e < 2; e++) begin
      chk("R11 second result", {26'd0, lv[e], lrt[e]}, {26'd0, 1'b1, 5'd12});
      chk("R11 second data", ldat[e], exp_ld(e, 6'd36, 32'h109));
    end

    // R12 reset drops a load in flight
    issue(6'd35, 32'h0000_0100, 16'h0, 5'd5, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      for (int e = 0; e < 2; e++) chk("R12 load dropped", {31'd0, lv[e]}, 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule